// File: doc/BRIEF.md
# Leaky-Bucket Hit Rate Limiter

This block goes on one channel, between a time-to-digital converter and the readout path. The converter raises a data-valid strobe with a time word for each hit it digitizes. The limiter decides in the same clock whether to pass that hit on. It makes the decision with an 8-bit unsigned bucket level that runs on the fast converter clock. An accepted hit pours a fixed weight of 32 into the bucket. Each cycle without a hit drains one unit. Once the level reaches seven hits' worth (224), further hits are refused, and each refused hit still drains one unit.

In the cycle after the hit, the block reports the result on registered outputs. An accepted hit gives a one-cycle valid pulse together with that hit's time word. A refused hit gives a one-cycle drop pulse. This bounds the long-term rate at one hit per 33 clocks. Short bursts of up to six hits still pass without loss. A synchronous spill-clear input empties the bucket at the start of each spill.

Top module: `hit_rate_limiter`

## Requirements
- R1: A hit that arrives while the level is below 224 is accepted: `acc_vld` is high for exactly the next cycle, `acc_time` carries that hit's `hit_time`, and the level rises by 32.
- R2: A hit that arrives while the level is 224 or more is refused: `hit_drop` is high for exactly the next cycle, `acc_vld` stays low, and the level falls by 1.
- R3: A cycle with no hit lowers the level by 1, and a level of 0 stays at 0.
- R4: The level never wraps. After any number of idle cycles, a burst of 8 back-to-back hits gives 7 accepts and 1 drop.
- R5: A continuous stream of back-to-back hits from an empty bucket gives 7 accepts, one drop, one accept, and then one accept per 33 hits. For example, 42 hits yield 9 accepts.
- R6: No 256-cycle window contains more than 15 accepted hits.
- R7: Six hits in any 262-cycle window are all accepted when they start from an empty bucket, whether back-to-back or spread out.
- R8: A steady stream with a hit period of 33 cycles or more loses no hits.
- R9: `spill_clr` high at a clock edge empties the bucket. Any hit in that cycle is discarded: neither `acc_vld` nor `hit_drop` follows.
- R10: `rst_n` low at a clock edge empties the bucket and drives `acc_vld`, `hit_drop` and `acc_time` to 0.
- R11: Every hit outside clear and reset yields exactly one of `acc_vld` or `hit_drop`, never both. Neither pulse appears without a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spill_clr | input | 1 | Synchronous clear at spill start |
| hit_vld | input | 1 | One-cycle strobe per digitized hit |
| hit_time | input | TIME_W (16) | Time word of the hit |
| acc_vld | output | 1 | One-cycle pulse per accepted hit |
| acc_time | output | TIME_W (16) | Time word of the accepted hit |
| hit_drop | output | 1 | One-cycle pulse per refused hit |

## Verification
Two things can land on the same edge: a spill clear and an incoming hit. The clear must win, and the hit must vanish without a pulse of either kind. The bench provokes this by filling the bucket with seven hits and then raising `spill_clr` together with `hit_vld`. It judges the result in two steps. First, both outputs must stay low in the following cycle. Second, a fresh burst of eight hits must show seven accepts and one drop, which is only possible if the clear emptied the bucket.

// File: rtl/hrl_pkg.sv
// Shared types for the hit rate limiter.
// Assumes: nothing beyond IEEE 1800-2017.
package hrl_pkg;

    // How the bucket level moves in one clock
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_DRAIN = 2'd1,
        STEP_POUR  = 2'd2,
        STEP_EMPTY = 2'd3
    } step_e;

endpackage

// File: rtl/hrl_bucket.sv
// Bucket level register and acceptance decision.
// Does: pours HIT_WEIGHT per accepted hit, drains 1 per idle or refused
// hit cycle, holds at zero, empties on clear.
// Assumes: THRESH-1+HIT_WEIGHT fits in ACC_W bits (checked by the top).
module hrl_bucket
    import hrl_pkg::*;
#(
    parameter int ACC_W      = 8,
    parameter int HIT_WEIGHT = 32,
    parameter int HIT_BUDGET = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hit_i,
    output logic             accept_o,
    output logic [ACC_W-1:0] level_o
);

    localparam int               THRESH   = HIT_WEIGHT * HIT_BUDGET;
    localparam logic [ACC_W-1:0] THRESH_L = ACC_W'(THRESH);
    localparam logic [ACC_W-1:0] WEIGHT_L = ACC_W'(HIT_WEIGHT);
    localparam logic [ACC_W-1:0] ONE_L    = ACC_W'(1);

    logic [ACC_W-1:0] level_q;
    step_e            step;

    // Decide acceptance from the level before this hit
    assign accept_o = hit_i && (level_q < THRESH_L);

    // Pick how the level moves this cycle
    always_comb begin
        if (clr_i)
            step = STEP_EMPTY;
        else if (accept_o)
            step = STEP_POUR;
        else if (level_q != '0)
            step = STEP_DRAIN;
        else
            step = STEP_HOLD;
    end

    // Level register, synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            unique case (step)
                STEP_EMPTY: level_q <= '0;
                STEP_POUR:  level_q <= level_q + WEIGHT_L;
                STEP_DRAIN: level_q <= level_q - ONE_L;
                default:    level_q <= level_q;
            endcase
        end
    end

    assign level_o = level_q;

    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == '0 && !hit_i && !clr_i) |=> (level_q == '0)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && level_q >= THRESH_L) |=> (level_q >= THRESH_L - ONE_L)); // R4
    AST_POUR_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && hit_i && level_q < THRESH_L) |=> (level_q > $past(level_q))); // R1

endmodule

// File: rtl/hrl_out_stage.sv
// Registered result stage.
// Does: turns the acceptance decision into one-cycle valid or drop pulses
// and captures the time word of accepted hits.
// Assumes: accept_i is only high together with hit_i.
module hrl_out_stage #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              hit_i,
    input  logic              accept_i,
    input  logic [TIME_W-1:0] time_i,
    output logic              vld_o,
    output logic [TIME_W-1:0] time_o,
    output logic              drop_o
);

    // Pulse registers; a clear swallows the hit of its own cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            drop_o <= 1'b0;
        end else begin
            vld_o  <= hit_i && accept_i && !clr_i;
            drop_o <= hit_i && !accept_i && !clr_i;
        end
    end

    // Time register, loaded only by accepted hits
    always_ff @(posedge clk) begin
        if (!rst_n)
            time_o <= '0;
        else if (hit_i && accept_i && !clr_i)
            time_o <= time_i;
    end

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vld_o, drop_o})); // R11
    AST_CLEAR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!vld_o && !drop_o)); // R9

endmodule

// File: rtl/hit_rate_limiter.sv
// Top of the per-channel leaky-bucket hit rate limiter.
// Does: passes converter hits while the bucket is below its budget,
// reports refused hits, empties on spill clear.
// Assumes: hit_vld is a one-cycle strobe per hit in the clk domain.
module hit_rate_limiter #(
    parameter int TIME_W     = 16,
    parameter int ACC_W      = 8,
    parameter int HIT_WEIGHT = 32,
    parameter int HIT_BUDGET = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spill_clr,
    input  logic              hit_vld,
    input  logic [TIME_W-1:0] hit_time,
    output logic              acc_vld,
    output logic [TIME_W-1:0] acc_time,
    output logic              hit_drop
);

    localparam int THRESH    = HIT_WEIGHT * HIT_BUDGET;
    localparam int PEAK      = THRESH - 1 + HIT_WEIGHT;
    localparam int LEVEL_MAX = (1 << ACC_W) - 1;

    // Refuse parameter sets whose peak level would wrap
    generate
        if (PEAK > LEVEL_MAX) begin : g_bad_width
            $error("hit_rate_limiter: ACC_W too narrow for weight and budget");
        end
    endgenerate

    logic             accept;
    logic [ACC_W-1:0] level;

    hrl_bucket #(
        .ACC_W      (ACC_W),
        .HIT_WEIGHT (HIT_WEIGHT),
        .HIT_BUDGET (HIT_BUDGET)
    ) i_bucket (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (spill_clr),
        .hit_i    (hit_vld),
        .accept_o (accept),
        .level_o  (level)
    );

    hrl_out_stage #(
        .TIME_W (TIME_W)
    ) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (spill_clr),
        .hit_i    (hit_vld),
        .accept_i (accept),
        .time_i   (hit_time),
        .vld_o    (acc_vld),
        .time_o   (acc_time),
        .drop_o   (hit_drop)
    );

    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        hit_drop |-> ($past(level) >= ACC_W'(THRESH))); // R2
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld || hit_drop) |-> ($past(hit_vld) && !$past(spill_clr))); // R11
    AST_TIME_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> (acc_time == $past(hit_time))); // R1

endmodule

// File: tb/test_hit_rate_limiter.sv
// Self-checking bench: vector table of hit streams, then directed tests.
module test_hit_rate_limiter;

    localparam int TIME_W = 16;
    localparam int N_VEC  = 9;
    // Hit period, hit count, expected accepts (from the requirements)
    localparam int VEC_PER [N_VEC] = '{1, 1, 1, 1, 33, 40, 2, 16, 44};
    localparam int VEC_CNT [N_VEC] = '{6, 8, 9, 42, 20, 10, 9, 16, 6};
    localparam int VEC_EXP [N_VEC] = '{6, 7, 8, 9, 20, 10, 8, 15, 6};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spill_clr = 1'b0;
    logic              hit_vld = 1'b0;
    logic [TIME_W-1:0] hit_time = '0;
    logic              acc_vld;
    logic [TIME_W-1:0] acc_time;
    logic              hit_drop;

    int                tests = 0;
    int                fails = 0;
    int                n_acc = 0;
    int                n_drop = 0;
    int                max_win = 0;
    logic [255:0]      win = '0;
    logic [TIME_W-1:0] tcnt = 16'h0100;
    logic [TIME_W-1:0] exp_time;
    bit                done = 1'b0;
    string             vec_req [N_VEC];

    always #5 clk = ~clk;

    hit_rate_limiter #(.TIME_W(TIME_W)) i_hit_rate_limiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .spill_clr (spill_clr),
        .hit_vld   (hit_vld),
        .hit_time  (hit_time),
        .acc_vld   (acc_vld),
        .acc_time  (acc_time),
        .hit_drop  (hit_drop)
    );

    // Record one check and report a failure
    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One clock: drive at falling edge, sample just after the rising edge
    task automatic tick(input logic h, input logic c, input logic r);
        @(negedge clk);
        hit_vld   = h;
        spill_clr = c;
        rst_n     = r;
        hit_time  = tcnt;
        exp_time  = tcnt;
        tcnt      = tcnt + 16'd7;
        @(posedge clk);
        #1;
        if (acc_vld) begin
            n_acc++;
            if (acc_time != exp_time) chk(1'b0, "R1 time", int'(acc_time), int'(exp_time));
        end
        if (hit_drop) n_drop++;
        if (acc_vld && hit_drop) chk(1'b0, "R11 both", 1, 0);
        if ((!h || c || !r) && (acc_vld || hit_drop))
            chk(1'b0, "R9/R11 phantom", int'({acc_vld, hit_drop}), 0);
        win = {win[254:0], acc_vld};
        if ($countones(win) > max_win) max_win = $countones(win);
    endtask

    task automatic clear_spill();
        tick(1'b0, 1'b1, 1'b1);
        n_acc  = 0;
        n_drop = 0;
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        vec_req = '{"R7 burst6", "R4/R5 burst8", "R2/R5 burst9", "R5 burst42",
                    "R8 period33", "R8 period40", "R2 period2", "R3 period16",
                    "R7 period44"};

        // R10: reset state, hits ignored while reset is low
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        chk(!acc_vld && !hit_drop && acc_time == '0, "R10 reset outputs",
            int'({acc_vld, hit_drop}), 0);
        tick(1'b0, 1'b0, 1'b1);

        // Vector table walk
        for (int v = 0; v < N_VEC; v++) begin
            clear_spill();
            for (int h = 0; h < VEC_CNT[v]; h++) begin
                tick(1'b1, 1'b0, 1'b1);
                for (int g = 1; g < VEC_PER[v]; g++) tick(1'b0, 1'b0, 1'b1);
            end
            chk(n_acc == VEC_EXP[v], vec_req[v], n_acc, VEC_EXP[v]);
            chk(n_acc + n_drop == VEC_CNT[v], "R11 one result per hit",
                n_acc + n_drop, VEC_CNT[v]);
        end

        // R1: single hit gives a one-cycle pulse with its time word
        clear_spill();
        tick(1'b1, 1'b0, 1'b1);
        chk(acc_vld && acc_time == exp_time, "R1 single accept", int'(acc_vld), 1);
        tick(1'b0, 1'b0, 1'b1);
        chk(!acc_vld, "R1 pulse one cycle", int'(acc_vld), 0);

        // R2: eighth back-to-back hit drops, pulse lasts one cycle
        clear_spill();
        burst(7);
        tick(1'b1, 1'b0, 1'b1);
        chk(hit_drop && !acc_vld, "R2 drop at full", int'(hit_drop), 1);
        tick(1'b0, 1'b0, 1'b1);
        chk(!hit_drop, "R2 drop one cycle", int'(hit_drop), 0);

        // R3: one idle cycle after seven hits drains below the threshold
        clear_spill();
        burst(7);
        tick(1'b0, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b1);
        chk(acc_vld, "R3 drain reopens", int'(acc_vld), 1);

        // R3/R4: long idle from empty, bucket must not wrap
        clear_spill();
        for (int i = 0; i < 1000; i++) tick(1'b0, 1'b0, 1'b1);
        burst(8);
        chk(n_acc == 7 && n_drop == 1, "R4 no wrap after idle", n_acc, 7);

        // R9: clear together with a hit, on a full bucket
        clear_spill();
        burst(7);
        tick(1'b1, 1'b1, 1'b1);
        chk(!acc_vld && !hit_drop, "R9 hit in clear cycle discarded",
            int'({acc_vld, hit_drop}), 0);
        n_acc = 0;
        n_drop = 0;
        burst(8);
        chk(n_acc == 7 && n_drop == 1, "R9 clear empties bucket", n_acc, 7);

        // R10: reset empties a full bucket
        clear_spill();
        burst(7);
        tick(1'b0, 1'b0, 1'b0);
        n_acc = 0;
        n_drop = 0;
        burst(7);
        chk(n_acc == 7 && n_drop == 0, "R10 reset empties bucket", n_acc, 7);

        // R6: 600-cycle continuous stream, sliding 256-cycle window
        clear_spill();
        win = '0;
        max_win = 0;
        burst(600);
        chk(max_win == 15, "R6 max accepts in 256 cycles", max_win, 15);

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

endmodule